// File: doc/BRIEF.md
# Serial TFT Panel Start-up and Pixel Streamer

This block runs a small TFT panel controller over a four-signal serial link: serial data out, serial clock, a data/command select and an active-low chip select. It also owns the panel's active-low reset line and a plain on/off backlight enable. Once the system leaves reset, the block first holds the panel in reset for a set time. It then releases the panel, waits, and plays a fixed start-up script from an internal table. The script is a mix of command bytes, parameter bytes and millisecond waits.

When the script is done, the block sends the memory-write command 0x2C. From then on it accepts 16-bit RGB565 pixels on a valid/ready stream. Each pixel goes onto the wire as two data bytes, high byte first, because the panel reads pixel data as big-endian.

Back-pressure rules for the pixel stream:
- `pix_ready` is low through reset and through the start-up script.
- `pix_ready` is low while the two bytes of the current pixel are shifting.
- A pixel is taken only in a cycle where `pix_valid` and `pix_ready` are both high.
- A source may hold `pix_valid` high for any length of time. It keeps its data stable until the transfer is taken.

Top module: `tft_serial_seq`

## Requirements
- R1: The serial clock idles low and is high only inside a byte. Serial data changes only on a falling clock edge and is stable while the clock is high. Each byte is sent most-significant bit first, one bit per clock period of 2*SCLK_HALF system clocks.
- R2: The data/command line is low (0) for every command byte and high (1) for every parameter byte and pixel byte. It does not change within a byte.
- R3: Chip select is low at every rising clock edge and goes low before the first rising edge of a transfer. It stays low from a command byte through that command's parameter bytes. It goes high for at least one system clock between two script commands.
- R4: After system reset the panel reset output is low for RESET_MS milliseconds (RESET_MS*CLKS_PER_MS system clocks) and then goes high. No serial clock edge occurs until a further POST_RESET_MS milliseconds have passed.
- R5: The script sends these bytes in this order: command 0x01; command 0x11; command 0x3A with parameter 0x55; command 0x21; command 0x29; command 0x36 with parameter 0x60; command 0xC6 with parameter 0x00.
- R6: Each script wait lasts WAIT_MS milliseconds. There are two waits after 0x01 and one wait after each of 0x11, the 0x3A/0x55 pair and 0x21. There are no waits between 0x29, 0x36 and 0xC6.
- R7: `init_done` is low until the last script entry has been sent, then goes high and stays high until reset. The backlight enable is low before that point and high from it onwards.
- R8: `pix_ready` is never high while `init_done` is low. Command 0x2C is sent with the data/command line low before any pixel byte.
- R9: A pixel is taken only on a cycle with `pix_valid` and `pix_ready` both high. `pix_ready` drops in the cycle after a handshake and stays low until both bytes of that pixel have been shifted. While `pix_valid` is low, no byte is sent.
- R10: Each pixel is sent as bits [15:8] and then bits [7:0]. Chip select stays low from command 0x2C through the whole pixel stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 16 | RGB565 pixel, red in [15:11] |
| pix_valid | input | 1 | Pixel present on pix_data |
| pix_ready | output | 1 | Block can take a pixel this cycle |
| lcd_sclk | output | 1 | Serial clock, idle low |
| lcd_mosi | output | 1 | Serial data to the panel |
| lcd_dc | output | 1 | 0 = command byte, 1 = parameter or pixel byte |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_rst_n | output | 1 | Active-low panel reset |
| lcd_bl_en | output | 1 | Backlight on when high |
| init_done | output | 1 | Start-up script finished |

## Verification
Most state errors in this block show up at the ports on the very next byte, as a wrong value or a wrong data/command level on the wire. Examples are a script index that skips or repeats, a shift register that starts at the wrong end, or a pixel latch that keeps the wrong half.

A miscounted millisecond timer shows up later and more quietly: only the spacing between serial bursts changes. It is caught by measuring the time between the first rising edges of script commands.

A controller state that misjudges the handshake shows up within one cycle at `pix_ready`, or later as a missing or extra byte in the captured stream.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    STEP_CMD  = 2'd0,
    STEP_PARM = 2'd1,
    STEP_WAIT = 2'd2
  } step_kind_e;

  typedef struct packed {
    step_kind_e kind;
    logic [7:0] data;
  } script_step_t;

  localparam int unsigned SCRIPT_LEN = 15;
  localparam logic [7:0]  OP_MEM_WRITE = 8'h2C;

  // Start-up script; indices past the end read as a wait step.
  function automatic script_step_t script_at(input logic [3:0] i);
    script_step_t s;
    s.kind = STEP_WAIT;
    s.data = 8'h00;
    case (i)
      4'd0:  begin s.kind = STEP_CMD;  s.data = 8'h01; end
      4'd1:  s.kind = STEP_WAIT;
      4'd2:  s.kind = STEP_WAIT;
      4'd3:  begin s.kind = STEP_CMD;  s.data = 8'h11; end
      4'd4:  s.kind = STEP_WAIT;
      4'd5:  begin s.kind = STEP_CMD;  s.data = 8'h3A; end
      4'd6:  begin s.kind = STEP_PARM; s.data = 8'h55; end
      4'd7:  s.kind = STEP_WAIT;
      4'd8:  begin s.kind = STEP_CMD;  s.data = 8'h21; end
      4'd9:  s.kind = STEP_WAIT;
      4'd10: begin s.kind = STEP_CMD;  s.data = 8'h29; end
      4'd11: begin s.kind = STEP_CMD;  s.data = 8'h36; end
      4'd12: begin s.kind = STEP_PARM; s.data = 8'h60; end
      4'd13: begin s.kind = STEP_CMD;  s.data = 8'hC6; end
      4'd14: begin s.kind = STEP_PARM; s.data = 8'h00; end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int unsigned CLKS_PER_MS = 80000,
  parameter int unsigned MS_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms,
  output logic            expired
);
  localparam int unsigned SUB_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_MS - 1);

  logic [SUB_W-1:0] sub_cnt;
  logic [MS_W-1:0]  ms_left;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_cnt <= '0;
      ms_left <= '0;
      active  <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        sub_cnt <= '0;
        ms_left <= ms;
        active  <= (ms != '0);
        expired <= (ms == '0);
      end else if (active) begin
        if (sub_cnt == SUB_LAST) begin
          sub_cnt <= '0;
          ms_left <= ms_left - 1'b1;
          if (ms_left == MS_W'(1)) begin
            active  <= 1'b0;
            expired <= 1'b1;
          end
        end else begin
          sub_cnt <= sub_cnt + 1'b1;
        end
      end
    end
  end

  // R6: a running wait always has at least one millisecond left
  p_active_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ms_left != '0));
  // R6: expiry is a single-cycle pulse unless restarted
  p_expire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !start) |=> !expired);

endmodule

// File: rtl/lcd_byte_tx.sv
module lcd_byte_tx #(
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       dc_in,
  output logic       sclk,
  output logic       mosi,
  output logic       dc,
  output logic       busy,
  output logic       done
);
  localparam int unsigned PH_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCLK_HALF - 1);

  logic [7:0]      shreg;
  logic [2:0]      bit_n;
  logic [PH_W-1:0] ph;

  assign mosi = shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      bit_n <= '0;
      ph    <= '0;
      sclk  <= 1'b0;
      dc    <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg <= din;
          dc    <= dc_in;
          bit_n <= '0;
          ph    <= '0;
          sclk  <= 1'b0;
          busy  <= 1'b1;
        end
      end else if (ph == PH_LAST) begin
        ph <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bit_n == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_n <= bit_n + 1'b1;
            shreg <= {shreg[6:0], 1'b0};
          end
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  // R1: clock rests low outside a byte
  p_sclk_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R1: data never moves while the clock is high
  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  // R2: data/command level is fixed for the whole byte
  p_dc_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dc));

endmodule

// File: rtl/tft_serial_seq.sv
module tft_serial_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned SCLK_HALF     = 2,
  parameter int unsigned CLKS_PER_MS   = 80000,
  parameter int unsigned WAIT_MS       = 120,
  parameter int unsigned RESET_MS      = 10,
  parameter int unsigned POST_RESET_MS = 120,
  parameter int unsigned MS_W          = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] pix_data,
  input  logic        pix_valid,
  output logic        pix_ready,
  output logic        lcd_sclk,
  output logic        lcd_mosi,
  output logic        lcd_dc,
  output logic        lcd_cs_n,
  output logic        lcd_rst_n,
  output logic        lcd_bl_en,
  output logic        init_done
);
  localparam logic [3:0] IDX_LAST = 4'(SCRIPT_LEN - 1);

  typedef enum logic [3:0] {
    S_BOOT, S_RST_HOLD, S_POST, S_FETCH, S_DELAY, S_XFER,
    S_MEMWR, S_MWAIT, S_READY, S_PHI, S_PLO
  } seq_state_e;

  seq_state_e   state;
  logic [3:0]   idx;
  script_step_t cur_step, nxt_step;
  logic         tmr_start, tmr_exp;
  logic [MS_W-1:0] tmr_ms;
  logic         tx_start, tx_dc, tx_busy, tx_done;
  logic [7:0]   tx_byte, pix_lo;

  assign cur_step  = script_at(idx);
  assign nxt_step  = script_at(idx + 4'd1);
  assign pix_ready = (state == S_READY);

  lcd_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .ms(tmr_ms), .expired(tmr_exp)
  );

  lcd_byte_tx #(.SCLK_HALF(SCLK_HALF)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .din(tx_byte), .dc_in(tx_dc),
    .sclk(lcd_sclk), .mosi(lcd_mosi), .dc(lcd_dc), .busy(tx_busy), .done(tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_BOOT;
      idx       <= '0;
      tmr_start <= 1'b0;
      tmr_ms    <= '0;
      tx_start  <= 1'b0;
      tx_dc     <= 1'b0;
      tx_byte   <= '0;
      pix_lo    <= '0;
      lcd_cs_n  <= 1'b1;
      lcd_rst_n <= 1'b0;
      lcd_bl_en <= 1'b0;
      init_done <= 1'b0;
    end else begin
      tmr_start <= 1'b0;
      tx_start  <= 1'b0;
      unique case (state)
        S_BOOT: begin
          tmr_start <= 1'b1;
          tmr_ms    <= MS_W'(RESET_MS);
          state     <= S_RST_HOLD;
        end
        S_RST_HOLD: if (tmr_exp) begin
          lcd_rst_n <= 1'b1;
          tmr_start <= 1'b1;
          tmr_ms    <= MS_W'(POST_RESET_MS);
          state     <= S_POST;
        end
        S_POST: if (tmr_exp) begin
          idx   <= '0;
          state <= S_FETCH;
        end
        S_FETCH: begin
          if (cur_step.kind == STEP_WAIT) begin
            tmr_start <= 1'b1;
            tmr_ms    <= MS_W'(WAIT_MS);
            state     <= S_DELAY;
          end else begin
            lcd_cs_n <= 1'b0;
            tx_start <= 1'b1;
            tx_byte  <= cur_step.data;
            tx_dc    <= (cur_step.kind == STEP_PARM);
            state    <= S_XFER;
          end
        end
        S_DELAY: if (tmr_exp) begin
          if (idx == IDX_LAST) state <= S_MEMWR;
          else begin idx <= idx + 4'd1; state <= S_FETCH; end
        end
        S_XFER: if (tx_done) begin
          if (nxt_step.kind != STEP_PARM) lcd_cs_n <= 1'b1;
          if (idx == IDX_LAST) state <= S_MEMWR;
          else begin idx <= idx + 4'd1; state <= S_FETCH; end
        end
        S_MEMWR: begin
          init_done <= 1'b1;
          lcd_bl_en <= 1'b1;
          lcd_cs_n  <= 1'b0;
          tx_start  <= 1'b1;
          tx_byte   <= OP_MEM_WRITE;
          tx_dc     <= 1'b0;
          state     <= S_MWAIT;
        end
        S_MWAIT: if (tx_done) state <= S_READY;
        S_READY: if (pix_valid) begin
          pix_lo   <= pix_data[7:0];
          tx_start <= 1'b1;
          tx_byte  <= pix_data[15:8];
          tx_dc    <= 1'b1;
          state    <= S_PHI;
        end
        S_PHI: if (tx_done) begin
          tx_start <= 1'b1;
          tx_byte  <= pix_lo;
          tx_dc    <= 1'b1;
          state    <= S_PLO;
        end
        S_PLO: if (tx_done) state <= S_READY;
        default: state <= S_BOOT;
      endcase
    end
  end

  // R3: the panel is selected whenever it is clocked
  p_cs_low_clocking_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_sclk |-> !lcd_cs_n);
  // R4: no selection while the panel is held in reset
  p_idle_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> (lcd_cs_n && !lcd_sclk));
  // R8: pixels are refused until the script has finished
  p_ready_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> init_done);
  // R7: done is sticky
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R9: an accepted pixel closes the ready window
  p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> !pix_ready);

endmodule

// File: tb/tft_serial_seq_tb.sv
module tft_serial_seq_tb;
  localparam int CPMS = 4;
  localparam int WMS  = 120;
  localparam int RMS  = 10;
  localparam int PMS  = 120;
  localparam int NEXP = 19;
  // {new transaction, dc, byte}
  localparam logic [9:0] EXP_SEQ [NEXP] = '{
    10'h201, 10'h211, 10'h23A, 10'h155, 10'h221, 10'h229, 10'h236, 10'h160,
    10'h2C6, 10'h100, 10'h22C, 10'h1D6, 10'h1BA, 10'h112, 10'h134, 10'h100,
    10'h1FF, 10'h180, 10'h101
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] pix_data = '0;
  logic pix_valid = 1'b0;
  logic pix_ready, lcd_sclk, lcd_mosi, lcd_dc, lcd_cs_n, lcd_rst_n, lcd_bl_en, init_done;

  int checks = 0, errors = 0, cyc = 0;
  int ncap = 0, nbit = 0, first_rise = -1;
  int bad_stab = 0, bad_cs = 0, bad_dc = 0, bad_ready = 0;
  logic [9:0] cap [0:31];
  int cap_cyc [0:31];
  logic [7:0] shv;
  logic newflag = 1'b1, bdc = 1'b0, prev_sclk = 1'b0, prev_mosi = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  tft_serial_seq #(.SCLK_HALF(2), .CLKS_PER_MS(CPMS), .WAIT_MS(WMS),
                   .RESET_MS(RMS), .POST_RESET_MS(PMS), .MS_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .lcd_sclk(lcd_sclk), .lcd_mosi(lcd_mosi), .lcd_dc(lcd_dc),
    .lcd_cs_n(lcd_cs_n), .lcd_rst_n(lcd_rst_n), .lcd_bl_en(lcd_bl_en), .init_done(init_done)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Panel-side monitor, sampled between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_cs_n) newflag = 1'b1;
      if (!init_done && pix_ready) bad_ready++;
      if (lcd_sclk && prev_sclk && lcd_mosi !== prev_mosi) bad_stab++;
      if (lcd_sclk && !prev_sclk) begin
        if (lcd_mosi !== prev_mosi) bad_stab++;
        if (lcd_cs_n) bad_cs++;
        if (first_rise < 0) first_rise = cyc;
        if (nbit == 0) begin bdc = lcd_dc; cap_cyc[ncap & 31] = cyc; end
        else if (lcd_dc !== bdc) bad_dc++;
        shv = {shv[6:0], lcd_mosi};
        nbit++;
        if (nbit == 8) begin
          cap[ncap & 31] = {newflag, bdc, shv};
          ncap++;
          nbit = 0;
          newflag = 1'b0;
        end
      end
    end
    prev_sclk = lcd_sclk;
    prev_mosi = lcd_mosi;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_pixel(input logic [15:0] p);
    @(negedge clk);
    while (!pix_ready) @(negedge clk);
    pix_data = p;
    pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R9 ready low after handshake", {31'd0, pix_ready}, 32'd0);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // Reset state
    chk("R4 panel reset low in reset", {31'd0, lcd_rst_n}, 32'd0);
    chk("R3 cs high in reset", {31'd0, lcd_cs_n}, 32'd1);
    chk("R1 sclk low in reset", {31'd0, lcd_sclk}, 32'd0);
    chk("R7 backlight off in reset", {31'd0, lcd_bl_en}, 32'd0);
    chk("R8 ready low in reset", {31'd0, pix_ready}, 32'd0);
    rst_n = 1'b1;
    while (cyc < RMS*CPMS - 5) @(negedge clk);
    chk("R4 panel reset still low", {31'd0, lcd_rst_n}, 32'd0);
    while (cyc < RMS*CPMS + 10) @(negedge clk);
    chk("R4 panel reset released", {31'd0, lcd_rst_n}, 32'd1);
    chk("R7 done low during script", {31'd0, init_done}, 32'd0);
    while (!init_done) @(negedge clk);
    chk("R7 backlight on with done", {31'd0, lcd_bl_en}, 32'd1);
    chk("R4 no clock before post-reset wait", {31'd0, first_rise >= (RMS+PMS)*CPMS}, 32'd1);
    while (ncap < 11) @(negedge clk);
    repeat (3) @(negedge clk);
    // Idle stream: nothing sent while valid is low
    chk("R9 ready high when idle", {31'd0, pix_ready}, 32'd1);
    repeat (60) @(negedge clk);
    chk("R9 no bytes without valid", ncap, 32'd11);
    send_pixel(16'hD6BA);
    send_pixel(16'h1234);
    send_pixel(16'h00FF);
    send_pixel(16'h8001);
    for (int w = 0; w < 3000 && ncap < NEXP; w++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R10 total byte count", ncap, NEXP);
    for (int i = 0; i < NEXP; i++) begin
      checks++;
      if (cap[i] !== EXP_SEQ[i]) begin
        errors++;
        $display("FAIL R5/R2/R3/R8/R10 byte %0d actual=%h expected=%h", i, cap[i], EXP_SEQ[i]);
      end
    end
    chk("R6 two waits after 0x01", {31'd0, (cap_cyc[1] - cap_cyc[0]) >= 2*WMS*CPMS}, 32'd1);
    chk("R6 one wait after 0x11", {31'd0, (cap_cyc[2] - cap_cyc[1]) >= WMS*CPMS &&
                                          (cap_cyc[2] - cap_cyc[1]) < 2*WMS*CPMS}, 32'd1);
    chk("R6 no wait after 0x29", {31'd0, (cap_cyc[6] - cap_cyc[5]) < WMS*CPMS}, 32'd1);
    chk("R1 data stable while clock high", bad_stab, 0);
    chk("R3 cs low at every rising edge", bad_cs, 0);
    chk("R2 dc steady within byte", bad_dc, 0);
    chk("R8 ready never high before done", bad_ready, 0);
    chk("R7 done stays high", {31'd0, init_done}, 32'd1);
    chk("R1 clock idle low at end", {31'd0, lcd_sclk}, 32'd0);
    finish_run();
  end
endmodule